// File: doc/BRIEF.md
# Debug-Port CPU Control Sequencer

This block sits on the host side of a four-wire boundary-scan port and steers the CPU of a 16-bit microcontroller target. A host issues one command at a time over a request/done handshake. The block then walks the target's TAP controller and issues a fixed series of 8-bit instruction shifts and 16-bit data shifts. It also drives the target's test clock line. Five commands cover CPU control: halt the core, release it through a reset pulse, load a CPU register, wait until the core reaches an instruction fetch, and read and check the port identifier. A sixth command resets the TAP controller.

The shift engine runs TCK from the system clock through a programmable divider. TMS and TDI change on the falling TCK edge and TDO is sampled on the rising TCK edge. Every shift starts and ends in Run-Test/Idle. Instruction opcodes, the TCK divider, the TAP reset length and the fetch-poll limit are parameters. An error flag and the last identifier byte are reported to the host when a command completes.

Top module: `dbg_cpu_seq`

## Requirements
- R1: Instruction shifts are 8 bits and data shifts are 16 bits, both sent most significant bit first. Each shift leaves Run-Test/Idle and returns to it (instruction path TMS 1,1,0,0; data path TMS 1,0,0; TMS high on the last bit, then 1, then 0). Bits captured from TDO are assembled first-bit-as-MSB.
- R2: TCK has a period of 2*TCK_HALF system clocks. TMS and TDI change only in the cycle TCK falls, and TDO is sampled when TCK rises.
- R3: Command 5 (TAP reset) holds TMS high for RST_CYC (default 6) consecutive TCK rising edges, then low for one, leaving the TAP in Run-Test/Idle.
- R4: Command 0 (halt) shifts instruction 0x41 (data-register select), data 0x3FFF (jump-to-self), instruction 0x13 (control-signal select), then data 0x2409.
- R5: Command 1 (release) shifts instruction 0x13, data 0x2C01 (reset asserted), data 0x2401 (reset removed), then instruction 0x15 (control release).
- R6: Command 2 (register load) first drives TCLK high, then shifts instruction 0x13, data 0x3401, instruction 0x41, data 0x4030 plus the register number, data equal to the value input, and instruction 0x21 (address capture). It then drives TCLK low and finally shifts instruction 0x13 and data 0x2401.
- R7: The register number occupies the low four bits of the opcode word: register 15 yields 0x403F and register 5 yields 0x4035.
- R8: Command 3 (fetch wait) shifts instruction 0x14 (control capture), then shifts data 0x0000 repeatedly until the captured word has bit 7 (mask 0x0080) set. The other captured bits are ignored.
- R9: If POLL_MAX data shifts in command 3 all return bit 7 clear, the command stops after exactly POLL_MAX shifts with the error flag set.
- R10: Command 4 (identifier check) shifts instruction 0xFF (bypass) and presents the captured byte on id_o. Only 0x89 or 0x91 completes without error.
- R11: A command is accepted when the block is idle and req_i is high; op_i is 3 bits with codes 0 to 5 as above. done_o is a one-cycle pulse, and a request that arrives while a command runs is ignored.
- R12: err_o is updated in the cycle after done_o and cleared when the next command is accepted. Op codes 6 and 7 finish with err_o set and perform no shift.
- R13: During reset, TCK and TMS are low, TCLK is high, and done_o, err_o and id_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Command request |
| op_i | input | 3 | Command code |
| reg_i | input | 4 | Register number for register load |
| data_i | input | 16 | Value for register load |
| done_o | output | 1 | One-cycle command completion pulse |
| err_o | output | 1 | Error result of the last command |
| id_o | output | 8 | Last identifier byte captured |
| tck_o | output | 1 | Test clock to target |
| tms_o | output | 1 | Test mode select to target |
| tdi_o | output | 1 | Test data to target |
| tdo_i | input | 1 | Test data from target |
| tclk_o | output | 1 | Target test clock line |

## Verification
The edge assertions assume that nothing but the shift engine moves TMS and TDI, and that the host issues one command and waits for done_o. The bench follows this: it raises req_i for a single cycle and waits for the completion pulse, except in the one scenario that deliberately injects a request mid-command. The assertions also assume that TDO changes only on TCK falling edges, as a compliant TAP does. The bench's target model updates TDO only there, so every sampled bit is stable half a TCK period before it is read.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int IR_W = 8;
  localparam int DR_W = 16;

  localparam logic [2:0] OP_HALT     = 3'd0;
  localparam logic [2:0] OP_RELEASE  = 3'd1;
  localparam logic [2:0] OP_LOADREG  = 3'd2;
  localparam logic [2:0] OP_FETCHW   = 3'd3;
  localparam logic [2:0] OP_IDCHK    = 3'd4;
  localparam logic [2:0] OP_TAPRST   = 3'd5;

  typedef enum logic [2:0] {
    K_END, K_IR, K_DR, K_RST, K_TLO, K_THI
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [DR_W-1:0]   val;
  } step_t;
endpackage

// File: rtl/dcs_tck_gen.sv
module dcs_tck_gen #(
  parameter int TCK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (TCK_HALF > 1) ? $clog2(TCK_HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tck_q, tck_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(TCK_HALF - 1));

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    tck_d = wrap ? ~tck_q : tck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tck_q <= tck_d;
    end
  end

  assign tck_o  = tck_q;
  assign rise_o = wrap & ~tck_q;
  assign fall_o = wrap & tck_q;
endmodule

// File: rtl/dcs_shift_eng.sv
module dcs_shift_eng
  import dcs_pkg::*;
#(
  parameter int RST_CYC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            start_i,
  input  kind_e           kind_i,
  input  logic [DR_W-1:0] val_i,
  input  logic            tdo_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [DR_W-1:0] cap_o,
  output logic            tms_o,
  output logic            tdi_o
);
  localparam int MAXC = (DR_W > RST_CYC) ? DR_W : RST_CYC;
  localparam int CNTW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {P_IDLE, P_PRE, P_SH, P_UPD, P_RTI, P_END} ph_e;

  ph_e             ph_q, ph_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [DR_W-1:0] sh_q, sh_d, cap_q, cap_d;
  kind_e           knd_q, knd_d;
  logic            shf_q, shf_d, tms_q, tms_d, tdi_q, tdi_d;
  logic            pre_last, sh_last;

  always_comb begin
    pre_last = (knd_q == K_IR) ? (cnt_q == CNTW'(3)) : (cnt_q == CNTW'(2));
    sh_last  = (knd_q == K_IR) ? (cnt_q == CNTW'(IR_W - 1)) : (cnt_q == CNTW'(DR_W - 1));
  end

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    cap_d  = cap_q;
    knd_d  = knd_q;
    shf_d  = shf_q;
    tms_d  = tms_q;
    tdi_d  = tdi_q;
    done_o = 1'b0;
    if (rise_i && shf_q) cap_d = {cap_q[DR_W-2:0], tdo_i};
    if (ph_q == P_IDLE) begin
      if (start_i) begin
        ph_d  = P_PRE;
        cnt_d = '0;
        knd_d = kind_i;
        sh_d  = (kind_i == K_IR) ? (val_i << (DR_W - IR_W)) : val_i;
        cap_d = '0;
      end
    end else if (fall_i) begin
      shf_d = 1'b0;
      case (ph_q)
        P_PRE: begin
          if (knd_q == K_RST) begin
            tms_d = 1'b1;
            if (cnt_q == CNTW'(RST_CYC - 1)) begin
              ph_d  = P_RTI;
              cnt_d = '0;
            end else cnt_d = cnt_q + 1'b1;
          end else begin
            tms_d = (knd_q == K_IR) ? (cnt_q < CNTW'(2)) : (cnt_q == '0);
            if (pre_last) begin
              ph_d  = P_SH;
              cnt_d = '0;
            end else cnt_d = cnt_q + 1'b1;
          end
        end
        P_SH: begin
          tdi_d = sh_q[DR_W-1];
          sh_d  = {sh_q[DR_W-2:0], 1'b0};
          shf_d = 1'b1;
          tms_d = sh_last;
          if (sh_last) begin
            ph_d  = P_UPD;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        P_UPD: begin
          tms_d = 1'b1;
          ph_d  = P_RTI;
        end
        P_RTI: begin
          tms_d = 1'b0;
          ph_d  = P_END;
        end
        P_END: begin
          done_o = 1'b1;
          ph_d   = P_IDLE;
        end
        default: ph_d = P_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= P_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      cap_q <= '0;
      knd_q <= K_END;
      shf_q <= 1'b0;
      tms_q <= 1'b0;
      tdi_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      cap_q <= cap_d;
      knd_q <= knd_d;
      shf_q <= shf_d;
      tms_q <= tms_d;
      tdi_q <= tdi_d;
    end
  end

  assign busy_o = (ph_q != P_IDLE);
  assign cap_o  = cap_q;
  assign tms_o  = tms_q;
  assign tdi_o  = tdi_q;
endmodule

// File: rtl/dcs_seq.sv
module dcs_seq
  import dcs_pkg::*;
#(
  parameter int              POLL_MAX    = 64,
  parameter logic [IR_W-1:0] IR_CTRL     = 8'h13,
  parameter logic [IR_W-1:0] IR_CTRL_CAP = 8'h14,
  parameter logic [IR_W-1:0] IR_CTRL_REL = 8'h15,
  parameter logic [IR_W-1:0] IR_DATA     = 8'h41,
  parameter logic [IR_W-1:0] IR_ADDR_CAP = 8'h21,
  parameter logic [IR_W-1:0] IR_BYP      = 8'hFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic [2:0]      op_i,
  input  logic [3:0]      reg_i,
  input  logic [DR_W-1:0] data_i,
  input  logic            eng_done_i,
  input  logic [DR_W-1:0] eng_cap_i,
  output logic            eng_start_o,
  output kind_e           eng_kind_o,
  output logic [DR_W-1:0] eng_val_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic [IR_W-1:0] id_o,
  output logic            tclk_o
);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam logic [IR_W-1:0] ID_A = 8'h89;
  localparam logic [IR_W-1:0] ID_B = 8'h91;

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_WAIT, S_DONE} st_e;

  function automatic step_t mk(input kind_e k, input logic [DR_W-1:0] v);
    step_t s;
    s.kind = k;
    s.val  = v;
    return s;
  endfunction

  function automatic logic [DR_W-1:0] irw(input logic [IR_W-1:0] c);
    return DR_W'(c);
  endfunction

  function automatic step_t step_at(input logic [2:0] o, input logic [3:0] i,
                                    input logic [3:0] r, input logic [DR_W-1:0] d);
    step_t s;
    s = mk(K_END, '0);
    case (o)
      OP_HALT: case (i)
        4'd0: s = mk(K_IR, irw(IR_DATA));
        4'd1: s = mk(K_DR, 16'h3FFF);
        4'd2: s = mk(K_IR, irw(IR_CTRL));
        4'd3: s = mk(K_DR, 16'h2409);
        default: s = mk(K_END, '0);
      endcase
      OP_RELEASE: case (i)
        4'd0: s = mk(K_IR, irw(IR_CTRL));
        4'd1: s = mk(K_DR, 16'h2C01);
        4'd2: s = mk(K_DR, 16'h2401);
        4'd3: s = mk(K_IR, irw(IR_CTRL_REL));
        default: s = mk(K_END, '0);
      endcase
      OP_LOADREG: case (i)
        4'd0: s = mk(K_THI, '0);
        4'd1: s = mk(K_IR, irw(IR_CTRL));
        4'd2: s = mk(K_DR, 16'h3401);
        4'd3: s = mk(K_IR, irw(IR_DATA));
        4'd4: s = mk(K_DR, 16'h4030 | DR_W'(r));
        4'd5: s = mk(K_DR, d);
        4'd6: s = mk(K_IR, irw(IR_ADDR_CAP));
        4'd7: s = mk(K_TLO, '0);
        4'd8: s = mk(K_IR, irw(IR_CTRL));
        4'd9: s = mk(K_DR, 16'h2401);
        default: s = mk(K_END, '0);
      endcase
      OP_FETCHW: case (i)
        4'd0: s = mk(K_IR, irw(IR_CTRL_CAP));
        4'd1: s = mk(K_DR, 16'h0000);
        default: s = mk(K_END, '0);
      endcase
      OP_IDCHK: if (i == 4'd0) s = mk(K_IR, irw(IR_BYP));
      OP_TAPRST: if (i == 4'd0) s = mk(K_RST, '0);
      default: s = mk(K_END, '0);
    endcase
    return s;
  endfunction

  st_e             st_q, st_d;
  logic [2:0]      op_q, op_d;
  logic [3:0]      rg_q, rg_d, idx_q, idx_d;
  logic [DR_W-1:0] dat_q, dat_d;
  logic [PW-1:0]   try_q, try_d;
  logic            pend_q, pend_d, err_q, err_d, tclk_q, tclk_d;
  logic [IR_W-1:0] id_q, id_d;
  step_t           cur;

  assign cur = step_at(op_q, idx_q, rg_q, dat_q);

  always_comb begin
    st_d        = st_q;
    op_d        = op_q;
    rg_d        = rg_q;
    dat_d       = dat_q;
    idx_d       = idx_q;
    try_d       = try_q;
    pend_d      = pend_q;
    err_d       = err_q;
    tclk_d      = tclk_q;
    id_d        = id_q;
    eng_start_o = 1'b0;
    done_o      = 1'b0;
    case (st_q)
      S_IDLE: if (req_i) begin
        op_d   = op_i;
        rg_d   = reg_i;
        dat_d  = data_i;
        idx_d  = '0;
        try_d  = '0;
        pend_d = (op_i > OP_TAPRST);
        err_d  = 1'b0;
        st_d   = S_STEP;
      end
      S_STEP: case (cur.kind)
        K_END: st_d = S_DONE;
        K_THI: begin
          tclk_d = 1'b1;
          idx_d  = idx_q + 1'b1;
        end
        K_TLO: begin
          tclk_d = 1'b0;
          idx_d  = idx_q + 1'b1;
        end
        default: begin
          eng_start_o = 1'b1;
          st_d        = S_WAIT;
        end
      endcase
      S_WAIT: if (eng_done_i) begin
        st_d  = S_STEP;
        idx_d = idx_q + 1'b1;
        if (op_q == OP_IDCHK && cur.kind == K_IR) begin
          id_d = eng_cap_i[IR_W-1:0];
          if (eng_cap_i[IR_W-1:0] != ID_A && eng_cap_i[IR_W-1:0] != ID_B) pend_d = 1'b1;
        end
        if (op_q == OP_FETCHW && cur.kind == K_DR && !eng_cap_i[7]) begin
          if (try_q == PW'(POLL_MAX - 1)) pend_d = 1'b1;
          else begin
            try_d = try_q + 1'b1;
            idx_d = idx_q;
          end
        end
      end
      S_DONE: begin
        done_o = 1'b1;
        err_d  = pend_q;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= '0;
      rg_q   <= '0;
      dat_q  <= '0;
      idx_q  <= '0;
      try_q  <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      tclk_q <= 1'b1;
      id_q   <= '0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      rg_q   <= rg_d;
      dat_q  <= dat_d;
      idx_q  <= idx_d;
      try_q  <= try_d;
      pend_q <= pend_d;
      err_q  <= err_d;
      tclk_q <= tclk_d;
      id_q   <= id_d;
    end
  end

  assign eng_kind_o = cur.kind;
  assign eng_val_o  = cur.val;
  assign busy_o     = (st_q != S_IDLE);
  assign err_o      = err_q;
  assign id_o       = id_q;
  assign tclk_o     = tclk_q;
endmodule

// File: rtl/dbg_cpu_seq.sv
module dbg_cpu_seq
  import dcs_pkg::*;
#(
  parameter int              TCK_HALF    = 2,
  parameter int              RST_CYC     = 6,
  parameter int              POLL_MAX    = 64,
  parameter logic [IR_W-1:0] IR_CTRL     = 8'h13,
  parameter logic [IR_W-1:0] IR_CTRL_CAP = 8'h14,
  parameter logic [IR_W-1:0] IR_CTRL_REL = 8'h15,
  parameter logic [IR_W-1:0] IR_DATA     = 8'h41,
  parameter logic [IR_W-1:0] IR_ADDR_CAP = 8'h21,
  parameter logic [IR_W-1:0] IR_BYP      = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic [2:0]  op_i,
  input  logic [3:0]  reg_i,
  input  logic [15:0] data_i,
  output logic        done_o,
  output logic        err_o,
  output logic [7:0]  id_o,
  output logic        tck_o,
  output logic        tms_o,
  output logic        tdi_o,
  input  logic        tdo_i,
  output logic        tclk_o
);
  logic            rs_q1, rs_q2, rst_s;
  logic            tck_rise, tck_fall;
  logic            eng_start, eng_busy, eng_done, seq_busy;
  kind_e           eng_kind;
  logic [DR_W-1:0] eng_val, eng_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_s = rs_q2;

  dcs_tck_gen #(.TCK_HALF(TCK_HALF)) tck_i (
    .clk(clk), .rst_n(rst_s), .tck_o(tck_o), .rise_o(tck_rise), .fall_o(tck_fall)
  );

  dcs_shift_eng #(.RST_CYC(RST_CYC)) eng_i (
    .clk(clk), .rst_n(rst_s), .rise_i(tck_rise), .fall_i(tck_fall),
    .start_i(eng_start), .kind_i(eng_kind), .val_i(eng_val), .tdo_i(tdo_i),
    .busy_o(eng_busy), .done_o(eng_done), .cap_o(eng_cap),
    .tms_o(tms_o), .tdi_o(tdi_o)
  );

  dcs_seq #(
    .POLL_MAX(POLL_MAX), .IR_CTRL(IR_CTRL), .IR_CTRL_CAP(IR_CTRL_CAP),
    .IR_CTRL_REL(IR_CTRL_REL), .IR_DATA(IR_DATA), .IR_ADDR_CAP(IR_ADDR_CAP),
    .IR_BYP(IR_BYP)
  ) seq_i (
    .clk(clk), .rst_n(rst_s), .req_i(req_i), .op_i(op_i), .reg_i(reg_i),
    .data_i(data_i), .eng_done_i(eng_done), .eng_cap_i(eng_cap),
    .eng_start_o(eng_start), .eng_kind_o(eng_kind), .eng_val_o(eng_val),
    .busy_o(seq_busy), .done_o(done_o), .err_o(err_o), .id_o(id_o),
    .tclk_o(tclk_o)
  );
endmodule

// File: rtl/dcs_chk.sv
module dcs_chk (
  input logic clk,
  input logic rst_n,
  input logic tck,
  input logic tms,
  input logic tdi,
  input logic tclk,
  input logic done,
  input logic err,
  input logic busy,
  input logic eng_start,
  input logic eng_busy
);
  // R2
  tms_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tms) |-> $fell(tck));

  // R2
  tdi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tdi) |-> $fell(tck));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(done));

  // R6
  tclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tclk));

  // R11
  eng_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !eng_busy);
endmodule

bind dbg_cpu_seq dcs_chk chk_i (
  .clk(clk), .rst_n(rst_s), .tck(tck_o), .tms(tms_o), .tdi(tdi_o),
  .tclk(tclk_o), .done(done_o), .err(err_o), .busy(seq_busy),
  .eng_start(eng_start), .eng_busy(eng_busy)
);

// File: tb/dbg_cpu_seq_tb_top.sv
`timescale 1ns/1ps
module dbg_cpu_seq_tb_top;
  localparam int POLLS = 5;

  logic        clk, rst_n, req, tdo;
  logic [2:0]  op;
  logic [3:0]  rg;
  logic [15:0] dat;
  logic        done, err, tck, tms, tdi, tclk;
  logic [7:0]  id;

  int tests = 0, fails = 0, cyc = 0, done_cnt = 0;

  dbg_cpu_seq #(.TCK_HALF(2), .RST_CYC(6), .POLL_MAX(POLLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .op_i(op), .reg_i(rg), .data_i(dat),
    .done_o(done), .err_o(err), .id_o(id), .tck_o(tck), .tms_o(tms),
    .tdi_o(tdi), .tdo_i(tdo), .tclk_o(tclk)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- target TAP model ----------------
  typedef enum logic [3:0] {
    TLR, RTI, SDS, CDR, SHDR, E1D, PD, E2D, UDR,
    SIS, CIR, SHIR, E1I, PI, E2I, UIR
  } tap_e;

  tap_e        tap = TLR;
  logic [7:0]  irsh = 8'h00, ir = 8'hFF, id_val = 8'h89;
  logic [15:0] drsh = 16'h0;
  int          log_n = 0, poll_cnt = 0, poll_base = 0, ready_at = 1;
  int          tms_run = 0, max_run = 0;
  logic [15:0] log_val [0:127];
  logic        log_dr  [0:127];
  logic        log_tc  [0:127];

  function automatic tap_e tap_next(tap_e s, logic m);
    case (s)
      TLR:  return m ? TLR : RTI;
      RTI:  return m ? SDS : RTI;
      SDS:  return m ? SIS : CDR;
      CDR:  return m ? E1D : SHDR;
      SHDR: return m ? E1D : SHDR;
      E1D:  return m ? UDR : PD;
      PD:   return m ? E2D : PD;
      E2D:  return m ? UDR : SHDR;
      UDR:  return m ? SDS : RTI;
      SIS:  return m ? TLR : CIR;
      CIR:  return m ? E1I : SHIR;
      SHIR: return m ? E1I : SHIR;
      E1I:  return m ? UIR : PI;
      PI:   return m ? E2I : PI;
      E2I:  return m ? UIR : SHIR;
      default: return m ? SDS : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    if (tms) begin
      tms_run <= tms_run + 1;
      if (tms_run + 1 > max_run) max_run <= tms_run + 1;
    end else tms_run <= 0;
    case (tap)
      CIR:  irsh <= id_val;
      SHIR: irsh <= {irsh[6:0], tdi};
      UIR: begin
        ir <= irsh;
        log_val[log_n] <= {8'h00, irsh};
        log_dr[log_n]  <= 1'b0;
        log_tc[log_n]  <= tclk;
        log_n <= log_n + 1;
      end
      CDR: begin
        if (ir == 8'h14) begin
          drsh <= (poll_cnt - poll_base + 1 >= ready_at) ? 16'h0080 : 16'hFF7F;
          poll_cnt <= poll_cnt + 1;
        end else drsh <= 16'h0000;
      end
      SHDR: drsh <= {drsh[14:0], tdi};
      UDR: begin
        log_val[log_n] <= drsh;
        log_dr[log_n]  <= 1'b1;
        log_tc[log_n]  <= tclk;
        log_n <= log_n + 1;
      end
      default: ;
    endcase
    tap <= tap_next(tap, tms);
  end

  always @(negedge tck)
    tdo <= (tap == SHIR) ? irsh[7] : (tap == SHDR) ? drsh[15] : 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic chk_ent(input int base, input int i, input bit is_dr,
                         input logic [15:0] v, input string rq);
    chk(log_dr[base+i] == is_dr && log_val[base+i] == v, rq,
        {15'd0, log_dr[base+i], log_val[base+i]}, {15'd0, is_dr, v});
  endtask

  task automatic run_cmd(input logic [2:0] o, input logic [3:0] r,
                         input logic [15:0] d);
    @(negedge clk);
    req = 1'b1; op = o; rg = r; dat = d;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(tck == 0 && tms == 0 && tclk == 1, "R13 pins", {tck, tms, tclk}, 3'b001);
    chk(done == 0 && err == 0 && id == 0, "R13 status", {done, err, id}, 0);
  endtask

  task automatic t_tck_period();
    realtime t0, t1;
    @(posedge tck); t0 = $realtime;
    @(posedge tck); t1 = $realtime;
    chk((t1 - t0) == 16.0, "R2 tck period", int'(t1 - t0), 16);
  endtask

  task automatic t_tapreset();
    int b = log_n;
    max_run = 0;
    run_cmd(3'd5, 0, 0);
    chk(max_run >= 6, "R3 tms high run", max_run, 6);
    chk(tap == RTI, "R3 ends idle", tap, RTI);
    chk(log_n == b && err == 0, "R3 no shifts", log_n - b, 0);
  endtask

  task automatic t_id(input logic [7:0] v, input bit bad);
    int b = log_n;
    id_val = v;
    run_cmd(3'd4, 0, 0);
    chk(log_n - b == 1, "R10 one shift", log_n - b, 1);
    chk_ent(b, 0, 0, 16'h00FF, "R10 bypass opcode");
    chk(id == v, "R10 id value", id, v);
    chk(err == bad, "R10 id error", err, bad);
  endtask

  task automatic t_halt();
    int b = log_n;
    run_cmd(3'd0, 0, 0);
    chk(log_n - b == 4, "R4 count", log_n - b, 4);
    chk_ent(b, 0, 0, 16'h0041, "R4 data select");
    chk_ent(b, 1, 1, 16'h3FFF, "R4 jump opcode R1");
    chk_ent(b, 2, 0, 16'h0013, "R4 ctrl select");
    chk_ent(b, 3, 1, 16'h2409, "R4 halt word");
    chk(err == 0, "R12 halt no err", err, 0);
  endtask

  task automatic t_release();
    int b = log_n;
    run_cmd(3'd1, 0, 0);
    chk(log_n - b == 4, "R5 count", log_n - b, 4);
    chk_ent(b, 0, 0, 16'h0013, "R5 ctrl select");
    chk_ent(b, 1, 1, 16'h2C01, "R5 reset on");
    chk_ent(b, 2, 1, 16'h2401, "R5 reset off");
    chk_ent(b, 3, 0, 16'h0015, "R5 release instr");
  endtask

  task automatic t_loadreg(input logic [3:0] r, input logic [15:0] v);
    int b = log_n;
    run_cmd(3'd2, r, v);
    chk(log_n - b == 8, "R6 count", log_n - b, 8);
    chk_ent(b, 0, 0, 16'h0013, "R6 ctrl");
    chk_ent(b, 1, 1, 16'h3401, "R6 word");
    chk_ent(b, 2, 0, 16'h0041, "R6 data select");
    chk_ent(b, 3, 1, 16'h4030 | {12'h0, r}, "R7 reg opcode");
    chk_ent(b, 4, 1, v, "R6 value R1");
    chk_ent(b, 5, 0, 16'h0021, "R6 addr capture");
    chk_ent(b, 6, 0, 16'h0013, "R6 ctrl again");
    chk_ent(b, 7, 1, 16'h2401, "R6 final word");
    chk(log_tc[b] == 1 && log_tc[b+5] == 1, "R6 tclk high early",
        {log_tc[b], log_tc[b+5]}, 2'b11);
    chk(log_tc[b+6] == 0 && tclk == 0, "R6 tclk low late", {log_tc[b+6], tclk}, 0);
  endtask

  task automatic t_fetch(input int ready, input bit bad, input int nshift);
    int b = log_n;
    ready_at = ready;
    poll_base = poll_cnt;
    run_cmd(3'd3, 0, 0);
    chk_ent(b, 0, 0, 16'h0014, "R8 capture instr");
    chk(log_n - b - 1 == nshift, bad ? "R9 poll count" : "R8 poll count",
        log_n - b - 1, nshift);
    chk(log_val[log_n-1] == 16'h0000, "R8 poll word", log_val[log_n-1], 0);
    chk(err == bad, bad ? "R9 err" : "R8 err", err, bad);
  endtask

  task automatic t_badop();
    int b = log_n;
    int d0 = done_cnt;
    run_cmd(3'd6, 0, 0);
    chk(done_cnt - d0 == 1, "R12 bad op done", done_cnt - d0, 1);
    chk(err == 1 && log_n == b, "R12 bad op err no shift", {err, 8'(log_n - b)}, 9'h100);
  endtask

  task automatic t_busy_req();
    int b = log_n;
    int d0 = done_cnt;
    @(negedge clk);
    req = 1'b1; op = 3'd0;
    @(negedge clk);
    req = 1'b0;
    repeat (60) @(negedge clk);
    req = 1'b1; op = 3'd1;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (done) break;
      @(negedge clk);
    end
    repeat (400) @(negedge clk);
    chk(done_cnt - d0 == 1, "R11 one done", done_cnt - d0, 1);
    chk(log_n - b == 4 && log_val[b+3] == 16'h2409, "R11 busy req ignored",
        log_n - b, 4);
  endtask

  initial begin
    req = 0; op = 0; rg = 0; dat = 0; rst_n = 0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_tck_period();
    t_tapreset();
    t_id(8'h89, 0);
    t_id(8'h91, 0);
    t_id(8'h55, 1);
    t_halt();                 // also clears err left by the bad id (R12)
    t_release();
    t_loadreg(4'd5, 16'hBEEF);
    t_loadreg(4'd15, 16'h8001);
    t_fetch(3, 0, 3);
    t_fetch(1, 0, 1);
    t_fetch(1000, 1, POLLS);
    t_badop();
    t_busy_req();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected below 150000", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule